// File: doc/BRIEF.md
# Inter-Core Mailbox Request Registers

This block lets a master processor core hand follow-on address and data words for a command to a slave core. It holds two 16-bit mailbox words and one control/status word. Each core reaches them through its own simple register port, which has an address select, a write enable, write data and a read strobe. The master port can read and write. The slave port can only read: its write strobe is discarded at the port.

A shared valid flag carries the handshake. The master fills one or both mailboxes, then sets the flag. This sends a one-cycle notification pulse to the slave. The slave reads the mailboxes the master filled, and the flag drops once the last of them has been read. The master polls the flag to learn when it may refill the mailboxes. If the master writes a mailbox while the flag is still up, the write is accepted and a sticky overrun bit records the hazard.

Address map on both ports: 0 selects mailbox A, 1 selects mailbox B, 2 selects the control/status word, and 3 reads as zero. In the control/status word, bit 0 is the valid flag, bit 1 is the overrun bit, bit 2 is the pending mark of mailbox A and bit 3 is the pending mark of mailbox B. All other bits read as zero.

Top module: `core_mailbox`

## Requirements
- R1: A synchronous reset clears both mailboxes, the pending marks, the valid flag, the overrun bit, the notification pulse and both read-data registers to zero.
- R2: A master write to address 0 or 1 stores the word in that mailbox. A master read strobe loads the addressed word into m_rdata at the next clock edge, and m_rdata holds it until the next read strobe.
- R3: A slave read strobe loads the addressed word into s_rdata at the next clock edge. Slave writes to any address leave the mailboxes and the control/status word unchanged.
- R4: A master write to address 2 with bit 0 set raises the valid flag at the next edge. A master write to address 2 with bit 0 clear never lowers the flag.
- R5: s_notify is high for exactly the one cycle that follows each master write to address 2 with bit 0 set.
- R6: A master write to mailbox A sets control bit 2, and a master write to mailbox B sets control bit 3. While the flag is up, a slave read of a mailbox clears that mailbox's pending mark. The flag drops at the edge after which no mark remains. When the flag is up and no mark is set, any slave mailbox read drops it. A master write and a slave read of the same mailbox in one cycle leave its mark set.
- R7: A master mailbox write while the flag is up sets the sticky overrun bit (control bit 1). A master write to address 2 with bit 1 set clears the overrun bit.
- R8: When the master sets the flag in the same cycle as a slave mailbox read, the flag ends up set and the pending marks are unchanged by that read.
- R9: A read of address 2 from either port returns the valid flag in bit 0, the overrun bit in bit 1 and the pending marks in bits 2 and 3, with zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_addr | input | 2 | Master register select |
| m_wr | input | 1 | Master write enable |
| m_wdata | input | 16 | Master write data |
| m_rd | input | 1 | Master read strobe |
| m_rdata | output | 16 | Master read data, registered |
| s_addr | input | 2 | Slave register select |
| s_wr | input | 1 | Slave write enable (discarded) |
| s_wdata | input | 16 | Slave write data (discarded) |
| s_rd | input | 1 | Slave read strobe; reading a mailbox consumes it |
| s_rdata | output | 16 | Slave read data, registered |
| mbx_valid | output | 1 | Data-waiting flag |
| s_notify | output | 1 | One-cycle pulse to the slave after a flag set |

## Verification
Every result of this block arrives one edge after the stimulus that causes it. Read data, the valid flag, the pending marks, the overrun bit and the notification pulse all appear in the cycle after the strobe or write that produced them. The bench drives each access just after a falling edge, lets one rising edge pass, and compares at the following falling edge. There, the registered outputs already reflect that edge. The pulse width is checked by sampling s_notify again one cycle later. Control/status state that has no pin of its own is read back through address 2 on the next access.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Register index layout on both ports
    localparam int unsigned MBX_DEF_DATA_W = 16;
    localparam int unsigned MBX_DEF_COUNT  = 2;

    // Control/status word bit positions
    localparam int unsigned CTRL_VALID_BIT = 0;
    localparam int unsigned CTRL_OVR_BIT   = 1;
    localparam int unsigned CTRL_PEND_LSB  = 2;

    // Role of a register port: decides whether writes pass
    typedef enum logic {
        ROLE_MASTER = 1'b0,
        ROLE_SLAVE  = 1'b1
    } port_role_e;

    // Handshake state carried as one record
    typedef struct packed {
        logic valid;
        logic overrun;
        logic notify;
    } hs_flags_t;

    function automatic logic role_can_write(port_role_e role);
        return (role == ROLE_MASTER);
    endfunction

    function automatic logic role_can_consume(port_role_e role);
        return (role == ROLE_SLAVE);
    endfunction

endpackage

// File: rtl/mbx_port.sv
module mbx_port
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W  = MBX_DEF_DATA_W,
    parameter int unsigned NUM_MBX = MBX_DEF_COUNT,
    parameter int unsigned ADDR_W  = $clog2(NUM_MBX + 1),
    parameter port_role_e  ROLE    = ROLE_MASTER
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [ADDR_W-1:0]               addr,
    input  logic                            wr,
    input  logic [DATA_W-1:0]               wdata,
    input  logic                            rd,
    input  logic [(NUM_MBX+1)*DATA_W-1:0]   view,
    output logic [NUM_MBX-1:0]              mbx_wr_hit,
    output logic [NUM_MBX-1:0]              mbx_rd_hit,
    output logic                            ctrl_wr,
    output logic [DATA_W-1:0]               wr_word,
    output logic [DATA_W-1:0]               rdata
);

    localparam int unsigned NUM_REGS = NUM_MBX + 1;
    localparam logic        WR_OK    = role_can_write(ROLE);
    localparam logic        RD_EATS  = role_can_consume(ROLE);

    logic              wr_gated;
    logic [DATA_W-1:0] rd_sel;

    // Write path is closed off for a read-only role
    assign wr_gated = WR_OK & wr;
    assign wr_word  = wr_gated ? wdata : '0;
    assign ctrl_wr  = wr_gated && (int'(addr) == NUM_MBX);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_MBX; gi++) begin : g_hit
            assign mbx_wr_hit[gi] = wr_gated && (int'(addr) == gi);
            assign mbx_rd_hit[gi] = RD_EATS & rd & (int'(addr) == gi);
        end
    endgenerate

    // Read select; addresses beyond the control word read zero
    always_comb begin
        rd_sel = '0;
        if (int'(addr) < NUM_REGS) begin
            rd_sel = view[int'(addr)*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= rd_sel;
        end
    end

endmodule

// File: rtl/mbx_store.sv
module mbx_store
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W  = MBX_DEF_DATA_W,
    parameter int unsigned NUM_MBX = MBX_DEF_COUNT
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_MBX-1:0]          wr_hit,
    input  logic [DATA_W-1:0]           wr_word,
    output logic [NUM_MBX*DATA_W-1:0]   store_flat
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_MBX; gi++) begin : g_word
            logic [DATA_W-1:0] word_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    word_q <= '0;
                end else if (wr_hit[gi]) begin
                    word_q <= wr_word;
                end
            end

            assign store_flat[gi*DATA_W +: DATA_W] = word_q;
        end
    endgenerate

endmodule

// File: rtl/mbx_handshake.sv
module mbx_handshake
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_MBX = MBX_DEF_COUNT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_MBX-1:0]  wr_hit,
    input  logic [NUM_MBX-1:0]  rd_hit,
    input  logic                ctrl_wr,
    input  logic                set_bit,
    input  logic                ovr_clr_bit,
    output hs_flags_t           flags,
    output logic [NUM_MBX-1:0]  pending
);

    hs_flags_t          flags_q, flags_n;
    logic [NUM_MBX-1:0] pend_q, pend_n;
    logic               set_req;
    logic               consume;

    always_comb begin
        set_req = ctrl_wr & set_bit;
        // A same-cycle set outranks the slave's consumption
        consume = flags_q.valid & ~set_req & (|rd_hit);

        for (int i = 0; i < NUM_MBX; i++) begin
            pend_n[i] = wr_hit[i] | (pend_q[i] & ~(consume & rd_hit[i]));
        end

        flags_n.valid   = set_req |
                          (flags_q.valid & ~(consume & ~(|pend_n)));
        flags_n.overrun = (flags_q.valid & (|wr_hit)) |
                          (flags_q.overrun & ~(ctrl_wr & ovr_clr_bit));
        flags_n.notify  = set_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            pend_q  <= '0;
        end else begin
            flags_q <= flags_n;
            pend_q  <= pend_n;
        end
    end

    assign flags   = flags_q;
    assign pending = pend_q;

endmodule

// File: rtl/core_mailbox.sv
module core_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W  = MBX_DEF_DATA_W,
    parameter int unsigned NUM_MBX = MBX_DEF_COUNT,
    parameter int unsigned ADDR_W  = $clog2(NUM_MBX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic              m_wr,
    input  logic [DATA_W-1:0] m_wdata,
    input  logic              m_rd,
    output logic [DATA_W-1:0] m_rdata,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic              s_wr,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic              s_rd,
    output logic [DATA_W-1:0] s_rdata,
    output logic              mbx_valid,
    output logic              s_notify
);

    localparam int unsigned VIEW_W = (NUM_MBX + 1) * DATA_W;

    logic [NUM_MBX-1:0]        m_wr_hit, m_rd_hit, s_wr_hit, s_rd_hit;
    logic [NUM_MBX-1:0]        any_wr_hit, any_rd_hit, pend_q;
    logic                      m_ctrl_wr, s_ctrl_wr, any_ctrl_wr;
    logic [DATA_W-1:0]         m_word, s_word, any_word, ctrl_word;
    logic [NUM_MBX*DATA_W-1:0] store_flat;
    logic [VIEW_W-1:0]         view;
    hs_flags_t                 flags;
    logic                      ovr_q;

    mbx_port #(
        .DATA_W(DATA_W), .NUM_MBX(NUM_MBX), .ADDR_W(ADDR_W), .ROLE(ROLE_MASTER)
    ) u_mport (
        .clk(clk), .rst(rst), .addr(m_addr), .wr(m_wr), .wdata(m_wdata),
        .rd(m_rd), .view(view), .mbx_wr_hit(m_wr_hit), .mbx_rd_hit(m_rd_hit),
        .ctrl_wr(m_ctrl_wr), .wr_word(m_word), .rdata(m_rdata)
    );

    mbx_port #(
        .DATA_W(DATA_W), .NUM_MBX(NUM_MBX), .ADDR_W(ADDR_W), .ROLE(ROLE_SLAVE)
    ) u_sport (
        .clk(clk), .rst(rst), .addr(s_addr), .wr(s_wr), .wdata(s_wdata),
        .rd(s_rd), .view(view), .mbx_wr_hit(s_wr_hit), .mbx_rd_hit(s_rd_hit),
        .ctrl_wr(s_ctrl_wr), .wr_word(s_word), .rdata(s_rdata)
    );

    // Role gating inside each port zeroes the disallowed side
    assign any_wr_hit  = m_wr_hit | s_wr_hit;
    assign any_rd_hit  = m_rd_hit | s_rd_hit;
    assign any_ctrl_wr = m_ctrl_wr | s_ctrl_wr;
    assign any_word    = m_word | s_word;

    mbx_store #(.DATA_W(DATA_W), .NUM_MBX(NUM_MBX)) u_store (
        .clk(clk), .rst(rst), .wr_hit(any_wr_hit), .wr_word(any_word),
        .store_flat(store_flat)
    );

    mbx_handshake #(.NUM_MBX(NUM_MBX)) u_hs (
        .clk(clk), .rst(rst), .wr_hit(any_wr_hit), .rd_hit(any_rd_hit),
        .ctrl_wr(any_ctrl_wr), .set_bit(any_word[CTRL_VALID_BIT]),
        .ovr_clr_bit(any_word[CTRL_OVR_BIT]), .flags(flags), .pending(pend_q)
    );

    always_comb begin
        ctrl_word                               = '0;
        ctrl_word[CTRL_VALID_BIT]               = flags.valid;
        ctrl_word[CTRL_OVR_BIT]                 = flags.overrun;
        ctrl_word[CTRL_PEND_LSB +: NUM_MBX]     = pend_q;
    end

    assign view      = {ctrl_word, store_flat};
    assign ovr_q     = flags.overrun;
    assign mbx_valid = flags.valid;
    assign s_notify  = flags.notify;

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned NUM_MBX = 2,
    parameter int unsigned ADDR_W  = $clog2(NUM_MBX + 1)
) (
    input logic                      clk,
    input logic                      rst,
    input logic [ADDR_W-1:0]         m_addr,
    input logic                      m_wr,
    input logic [DATA_W-1:0]         m_wdata,
    input logic [ADDR_W-1:0]         s_addr,
    input logic                      s_rd,
    input logic                      valid,
    input logic                      notify,
    input logic                      overrun,
    input logic [NUM_MBX*DATA_W-1:0] store_flat
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(NUM_MBX);

    logic set_w, s_mbx_rd, m_mbx_wr;
    assign set_w    = m_wr && (m_addr == CTRL_A) && m_wdata[0];
    assign s_mbx_rd = s_rd && (s_addr < CTRL_A);
    assign m_mbx_wr = m_wr && (m_addr < CTRL_A);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!valid && !notify && !overrun && store_flat == '0));

    p_slave_nowrite_r3: assert property (@(posedge clk) disable iff (rst)
        !m_wr |=> $stable(store_flat));

    p_set_raises_r4: assert property (@(posedge clk) disable iff (rst)
        set_w |=> valid);

    p_notify_follows_r5: assert property (@(posedge clk) disable iff (rst)
        set_w |=> notify);

    p_notify_cause_r5: assert property (@(posedge clk) disable iff (rst)
        notify |-> $past(set_w));

    p_drop_by_read_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(valid) && !$past(rst)) |-> $past(s_mbx_rd));

    p_overrun_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (m_mbx_wr && valid) |=> overrun);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (set_w && s_mbx_rd) |=> valid);

endmodule

bind core_mailbox mbx_checker #(
    .DATA_W(DATA_W), .NUM_MBX(NUM_MBX), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .m_addr(m_addr), .m_wr(m_wr), .m_wdata(m_wdata),
    .s_addr(s_addr), .s_rd(s_rd), .valid(mbx_valid), .notify(s_notify),
    .overrun(ovr_q), .store_flat(store_flat)
);

// File: tb/core_mailbox_bench.sv
module core_mailbox_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    // Vector: {op[1:0], addr[1:0], data[15:0], expect[15:0]}
    // op 0 = master write, 1 = master read, 2 = slave write, 3 = slave read
    localparam logic [35:0] VEC [NVEC] = '{
        {2'd0, 2'd0, 16'h1234, 16'h0000},  // R2 fill A
        {2'd1, 2'd0, 16'h0000, 16'h1234},  // R2 read A
        {2'd0, 2'd1, 16'hABCD, 16'h0000},  // R2 fill B
        {2'd1, 2'd1, 16'h0000, 16'hABCD},  // R2 read B
        {2'd2, 2'd0, 16'hFFFF, 16'h0000},  // R3 slave write ignored
        {2'd3, 2'd0, 16'h0000, 16'h1234},  // R3 slave read A
        {2'd1, 2'd2, 16'h0000, 16'h000C},  // R6 R9 both pending, flag low
        {2'd0, 2'd2, 16'h0001, 16'h0000},  // R4 set flag
        {2'd1, 2'd2, 16'h0000, 16'h000D},  // R9 flag up
        {2'd3, 2'd0, 16'h0000, 16'h1234},  // R6 consume A
        {2'd3, 2'd2, 16'h0000, 16'h0009},  // R6 R9 only B pending
        {2'd3, 2'd1, 16'h0000, 16'hABCD},  // R6 consume B, flag drops
        {2'd1, 2'd2, 16'h0000, 16'h0000},  // R6 all clear
        {2'd2, 2'd2, 16'h0001, 16'h0000},  // R3 slave cannot set flag
        {2'd1, 2'd2, 16'h0000, 16'h0000},  // R3 control unchanged
        {2'd2, 2'd1, 16'h5555, 16'h0000}   // R3 slave write B ignored
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  m_addr = '0, s_addr = '0;
    logic        m_wr = 1'b0, m_rd = 1'b0, s_wr = 1'b0, s_rd = 1'b0;
    logic [15:0] m_wdata = '0, s_wdata = '0;
    logic [15:0] m_rdata, s_rdata;
    logic        mbx_valid, s_notify;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    core_mailbox u_core_mailbox (
        .clk(clk), .rst(rst),
        .m_addr(m_addr), .m_wr(m_wr), .m_wdata(m_wdata), .m_rd(m_rd), .m_rdata(m_rdata),
        .s_addr(s_addr), .s_wr(s_wr), .s_wdata(s_wdata), .s_rd(s_rd), .s_rdata(s_rdata),
        .mbx_valid(mbx_valid), .s_notify(s_notify)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one access cycle after a falling edge; return at the next falling edge
    task automatic cyc(input logic mw, input logic mr, input logic [1:0] ma, input logic [15:0] md,
                       input logic sw, input logic sr, input logic [1:0] sa, input logic [15:0] sd);
        m_wr = mw; m_rd = mr; m_addr = ma; m_wdata = md;
        s_wr = sw; s_rd = sr; s_addr = sa; s_wdata = sd;
        @(posedge clk);
        @(negedge clk);
        m_wr = 1'b0; m_rd = 1'b0; s_wr = 1'b0; s_rd = 1'b0;
    endtask

    task automatic idle();
        cyc(0, 0, 2'd0, 16'h0, 0, 0, 2'd0, 16'h0);
    endtask

    task automatic m_ctrl_read(input string tag, input logic [15:0] exp);
        cyc(0, 1, 2'd2, 16'h0, 0, 0, 2'd0, 16'h0);
        check(tag, m_rdata, exp);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 valid after reset", {15'h0, mbx_valid}, 16'h0);
        check("R1 notify after reset", {15'h0, s_notify}, 16'h0);
        check("R1 m_rdata after reset", m_rdata, 16'h0);
        m_ctrl_read("R1 control after reset", 16'h0000);
        cyc(0, 0, 2'd0, 16'h0, 0, 1, 2'd0, 16'h0);
        check("R1 mailbox A after reset", s_rdata, 16'h0000);

        // Vector walk
        for (int k = 0; k < NVEC; k++) begin
            logic [1:0]  op;
            logic [1:0]  ad;
            logic [15:0] dt, ex;
            {op, ad, dt, ex} = VEC[k];
            case (op)
                2'd0: cyc(1, 0, ad, dt, 0, 0, 2'd0, 16'h0);
                2'd1: begin
                    cyc(0, 1, ad, 16'h0, 0, 0, 2'd0, 16'h0);
                    check($sformatf("R2/R9 vector %0d master read", k), m_rdata, ex);
                end
                2'd2: cyc(0, 0, 2'd0, 16'h0, 1, 0, ad, dt);
                default: begin
                    cyc(0, 0, 2'd0, 16'h0, 0, 1, ad, 16'h0);
                    check($sformatf("R3/R6 vector %0d slave read", k), s_rdata, ex);
                end
            endcase
        end
        cyc(0, 1, 2'd1, 16'h0, 0, 0, 2'd0, 16'h0);
        check("R3 mailbox B after slave write", m_rdata, 16'hABCD);

        // R5 notify pulse width, R4 set
        cyc(1, 0, 2'd2, 16'h0001, 0, 0, 2'd0, 16'h0);
        check("R5 notify after set", {15'h0, s_notify}, 16'h1);
        check("R4 flag after set", {15'h0, mbx_valid}, 16'h1);
        idle();
        check("R5 notify one cycle only", {15'h0, s_notify}, 16'h0);

        // R4 writing 0 to flag bit keeps it
        cyc(1, 0, 2'd2, 16'h0000, 0, 0, 2'd0, 16'h0);
        check("R4 flag kept by zero write", {15'h0, mbx_valid}, 16'h1);
        check("R5 no notify on zero write", {15'h0, s_notify}, 16'h0);

        // R6 flag up with nothing pending: any mailbox read drops it
        cyc(0, 0, 2'd0, 16'h0, 0, 1, 2'd1, 16'h0);
        check("R6 read B data", s_rdata, 16'hABCD);
        check("R6 flag drops without pending", {15'h0, mbx_valid}, 16'h0);

        // R7 overrun set and clear
        cyc(1, 0, 2'd2, 16'h0001, 0, 0, 2'd0, 16'h0);
        cyc(1, 0, 2'd0, 16'h5A5A, 0, 0, 2'd0, 16'h0);
        m_ctrl_read("R7 overrun set", 16'h0007);
        cyc(1, 0, 2'd2, 16'h0002, 0, 0, 2'd0, 16'h0);
        m_ctrl_read("R7 overrun cleared", 16'h0005);

        // R6 write and read of same mailbox in one cycle: mark stays
        cyc(1, 0, 2'd0, 16'h1111, 0, 1, 2'd0, 16'h0);
        check("R6 slave saw old word", s_rdata, 16'h5A5A);
        check("R6 flag held by fresh write", {15'h0, mbx_valid}, 16'h1);
        m_ctrl_read("R6 R7 mark kept, overrun again", 16'h0007);
        cyc(1, 0, 2'd2, 16'h0002, 0, 0, 2'd0, 16'h0);
        cyc(0, 0, 2'd0, 16'h0, 0, 1, 2'd0, 16'h0);
        check("R6 new word read", s_rdata, 16'h1111);
        check("R6 flag drops after last read", {15'h0, mbx_valid}, 16'h0);

        // R8 set and consume in the same cycle
        cyc(1, 0, 2'd1, 16'h2222, 0, 0, 2'd0, 16'h0);
        cyc(1, 0, 2'd2, 16'h0001, 0, 1, 2'd1, 16'h0);
        check("R8 flag set wins", {15'h0, mbx_valid}, 16'h1);
        m_ctrl_read("R8 mark B kept", 16'h0009);
        cyc(0, 0, 2'd0, 16'h0, 0, 1, 2'd1, 16'h0);
        check("R8 later read consumes", {15'h0, mbx_valid}, 16'h0);

        // R1 reset in the middle of a transfer
        cyc(1, 0, 2'd2, 16'h0001, 0, 0, 2'd0, 16'h0);
        rst = 1'b1;
        idle();
        rst = 1'b0;
        check("R1 flag cleared by reset", {15'h0, mbx_valid}, 16'h0);
        check("R1 notify cleared by reset", {15'h0, s_notify}, 16'h0);
        cyc(0, 1, 2'd0, 16'h0, 0, 0, 2'd0, 16'h0);
        check("R1 mailbox A cleared", m_rdata, 16'h0000);
        m_ctrl_read("R1 control cleared", 16'h0000);

        finish_run();
    end

endmodule